// File: doc/BRIEF.md
# Redundant Link CRC Selector

The block sits behind two receivers that each deliver a copy of the same data block as a stream of 16-bit words. Each copy ends with three check words, which are CRC-16 values computed by the sender. As words arrive, the block computes the same three checksums per link: one over the even-numbered payload words, one over the odd-numbered payload words and one over the whole payload. It also stores each copy in a per-link buffer. When both copies have ended, the block judges each copy. It then replays one copy unchanged on a single output stream. The first link wins when its copy is clean, the second link is used when only the second copy is clean, and the first link is forwarded with a both-bad mark when neither copy is clean.

Software-facing state is kept to plain pins. These pins are a failed-copy counter per link, a both-bad counter, a clear strobe for all counters, the checksum values from the most recent block of each link, the pass flags of the last decision and the link that was forwarded.

Both streams use valid/ready. A word moves on an input or on the output only in a cycle where valid and ready are both high. A sender holding valid must keep its word until it is taken. The output holds its word and its last flag stable while `out_ready` is low. Each link stops taking words after its own last word and stays stopped until the forwarded block has fully left. The faster link therefore waits for the slower one, and a stalled output back-pressures both links.

Top module: `crcsel_top`

## Requirements
- R1: Checksums use CRC-16 with generator 0x1021 and start value 0xFFFF, and process each word most significant bit first. The payload is every word except the final three. The even checksum covers payload words 0, 2, 4 and so on. The odd checksum covers payload words 1, 3, 5 and so on. The block checksum covers all payload words. The final three words carry the expected even, odd and block checksums, in that order.
- R2: A copy passes only when all of the following hold: it is at least 4 words long, it is no longer than DEPTH words, and all three trailer words equal the computed checksums.
- R3: The output uses link 0 when copy 0 passes, link 1 when only copy 1 passes, and link 0 when neither passes.
- R4: The output sends the chosen copy word for word, with `out_last` high only on its final word. It starts only after both links have delivered their last word. A copy longer than DEPTH is sent as its first DEPTH words.
- R5: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` stay unchanged in the next cycle.
- R6: `out_valid` goes low in the cycle after the final word has been taken, and it stays low until the next decision.
- R7: A link's `in_ready` is low from the cycle after its last word until the forwarded block has left. Both `in_ready` bits are low while `out_valid` is high.
- R8: At each decision, `err_cnt` of every failing link goes up by one, and `both_bad_cnt` goes up by one when both copies fail.
- R9: A high `cnt_clear` sets all counters to zero at the next edge, and this takes priority over a decision in the same cycle.
- R10: `crc_even`, `crc_odd` and `crc_block` of a link hold the checksums computed over the most recent completed block on that link. `link_ok` and `sel_link` show the pass flags and the chosen link of the latest decision.
- R11: After reset, `out_valid` is low, both `in_ready` bits are high and all counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 2 | Word present, one bit per link |
| in_ready | output | 2 | Link may deliver a word |
| in_data | input | 2x16 | Word per link |
| in_last | input | 2 | Final word of the block, per link |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | 16 | Forwarded word |
| out_last | output | 1 | Final forwarded word |
| cnt_clear | input | 1 | Zero all counters |
| err_cnt | output | 2xCNT_W | Failed copies per link |
| both_bad_cnt | output | CNT_W | Decisions where both copies failed |
| crc_even | output | 2x16 | Last even-word checksum per link |
| crc_odd | output | 2x16 | Last odd-word checksum per link |
| crc_block | output | 2x16 | Last whole-payload checksum per link |
| link_ok | output | 2 | Pass flags of the latest decision |
| sel_link | output | 1 | Link forwarded at the latest decision |

## Verification
The bench sends blocks that fail in only one way each: a flipped payload word, a flipped even trailer, a flipped odd trailer, a flipped block trailer, a three-word block whose trailer matches, and a block longer than the buffer. A design that judged only the block checksum, or that counted the trailer in its own checksum, would then forward the wrong link or miscount. The bench also staggers the two links by many cycles and applies random output back-pressure. Under those conditions, a selector that started early, took words after a last, or dropped or repeated a word under stall would show a mismatched word, a wrong `out_last`, or a link ready that should be low. It also runs the four pass/fail combinations of the two copies, so that the link-0 preference and the both-bad counter are both exercised.

// File: rtl/crcsel_pkg.sv
package crcsel_pkg;
  localparam int WORD_W = 16;
  localparam int NLINK = 2;
  localparam int TRAIL_N = 3;
  localparam logic [WORD_W-1:0] CRC_GEN = 16'h1021;
  localparam logic [WORD_W-1:0] CRC_SEED = 16'hFFFF;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic {PH_COLLECT, PH_DRAIN} phase_e;

  typedef struct packed {
    word_t even;
    word_t odd;
    word_t blk;
  } crc_set_t;

  // One 16-bit word folded into a running CRC, msb first
  function automatic word_t crc_fold(word_t acc, word_t w);
    word_t c;
    logic fb;
    c = acc;
    for (int b = WORD_W - 1; b >= 0; b--) begin
      fb = c[WORD_W-1] ^ w[b];
      c = {c[WORD_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_GEN;
    end
    return c;
  endfunction
endpackage

// File: rtl/crcsel_link_check.sv
module crcsel_link_check
  import crcsel_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     restart,
  input  logic     acc,
  input  word_t    data,
  input  logic     last,
  output logic     pass,
  output crc_set_t crc_rd
);
  // hist[0] is the oldest held word; a word enters the checksums only
  // once three newer words exist, so the trailer never feeds itself
  word_t [TRAIL_N-1:0] hist;
  logic [1:0]          held;
  logic                odd_ph;
  crc_set_t            run, nxt;
  logic                feed;

  always_comb begin
    feed     = acc && (held == 2'(TRAIL_N));
    nxt      = run;
    if (feed) begin
      nxt.blk = crc_fold(run.blk, hist[0]);
      if (odd_ph) nxt.odd  = crc_fold(run.odd, hist[0]);
      else        nxt.even = crc_fold(run.even, hist[0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist   <= '0;
      held   <= '0;
      odd_ph <= 1'b0;
      run    <= '{even: CRC_SEED, odd: CRC_SEED, blk: CRC_SEED};
      pass   <= 1'b0;
      crc_rd <= '{even: CRC_SEED, odd: CRC_SEED, blk: CRC_SEED};
    end else if (restart) begin
      held   <= '0;
      odd_ph <= 1'b0;
      run    <= '{even: CRC_SEED, odd: CRC_SEED, blk: CRC_SEED};
    end else if (acc) begin
      hist <= {data, hist[TRAIL_N-1:1]};
      if (held != 2'(TRAIL_N)) held <= held + 2'd1;
      if (feed) odd_ph <= ~odd_ph;
      run <= nxt;
      if (last) begin
        pass   <= (held == 2'(TRAIL_N)) && (nxt.even == hist[1]) &&
                  (nxt.odd == hist[2]) && (nxt.blk == data);
        crc_rd <= nxt;
      end
    end
  end
endmodule

// File: rtl/crcsel_link_buf.sv
module crcsel_link_buf
  import crcsel_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          wr,
  input  word_t         wdata,
  input  logic [LW-1:0] raddr,
  output word_t         rdata,
  output logic [LW-1:0] count,
  output logic          ovf
);
  word_t mem [DEPTH];
  logic  full;

  assign full  = (count == LW'(DEPTH));
  assign rdata = mem[raddr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr && !full) mem[count[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (wr) begin
      if (full) ovf <= 1'b1;
      else      count <= count + LW'(1);
    end
  end
endmodule

// File: rtl/crcsel_top.sv
module crcsel_top
  import crcsel_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            in_valid,
  output logic [1:0]            in_ready,
  input  logic [1:0][15:0]      in_data,
  input  logic [1:0]            in_last,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [15:0]           out_data,
  output logic                  out_last,
  input  logic                  cnt_clear,
  output logic [1:0][CNT_W-1:0] err_cnt,
  output logic [CNT_W-1:0]      both_bad_cnt,
  output logic [1:0][15:0]      crc_even,
  output logic [1:0][15:0]      crc_odd,
  output logic [1:0][15:0]      crc_block,
  output logic [1:0]            link_ok,
  output logic                  sel_link
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  phase_e          phase;
  logic [NLINK-1:0] done, acc, pass, ovf, ok;
  word_t           rdata [NLINK];
  logic [LW-1:0]   cnt [NLINK];
  crc_set_t        crc_rd [NLINK];
  logic [LW-1:0]   rd_ptr, len;
  logic            sel, decide, restart, nxt_sel;

  for (genvar g = 0; g < NLINK; g++) begin : g_link
    assign in_ready[g] = (phase == PH_COLLECT) && !done[g];
    assign acc[g]      = in_valid[g] && in_ready[g];
    assign ok[g]       = pass[g] && !ovf[g];

    crcsel_link_check u_chk (
      .clk(clk), .rst_n(rst_n), .restart(restart), .acc(acc[g]),
      .data(in_data[g]), .last(in_last[g]), .pass(pass[g]), .crc_rd(crc_rd[g])
    );

    crcsel_link_buf #(.DEPTH(DEPTH)) u_buf (
      .clk(clk), .rst_n(rst_n), .restart(restart), .wr(acc[g]),
      .wdata(in_data[g]), .raddr(rd_ptr), .rdata(rdata[g]),
      .count(cnt[g]), .ovf(ovf[g])
    );

    assign crc_even[g]  = crc_rd[g].even;
    assign crc_odd[g]   = crc_rd[g].odd;
    assign crc_block[g] = crc_rd[g].blk;

    always_ff @(posedge clk) begin
      if (!rst_n)                   done[g] <= 1'b0;
      else if (restart)             done[g] <= 1'b0;
      else if (acc[g] && in_last[g]) done[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n || cnt_clear) err_cnt[g] <= '0;
      else if (decide && !ok[g]) err_cnt[g] <= err_cnt[g] + CNT_W'(1);
    end
  end

  assign decide    = (phase == PH_COLLECT) && (&done);
  assign nxt_sel   = !ok[0] && ok[1];
  assign out_valid = (phase == PH_DRAIN);
  assign out_data  = sel ? rdata[1] : rdata[0];
  assign out_last  = out_valid && (rd_ptr == len - LW'(1));
  assign restart   = out_valid && out_ready && out_last;
  assign sel_link  = sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_COLLECT;
      sel     <= 1'b0;
      link_ok <= '0;
      len     <= '0;
      rd_ptr  <= '0;
    end else if (decide) begin
      phase   <= PH_DRAIN;
      sel     <= nxt_sel;
      link_ok <= ok;
      len     <= nxt_sel ? cnt[1] : cnt[0];
      rd_ptr  <= '0;
    end else if (out_valid && out_ready) begin
      if (out_last) phase  <= PH_COLLECT;
      else          rd_ptr <= rd_ptr + LW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || cnt_clear)         both_bad_cnt <= '0;
    else if (decide && ok == 2'b00)  both_bad_cnt <= both_bad_cnt + CNT_W'(1);
  end
endmodule

// File: rtl/crcsel_sva.sv
module crcsel_sva #(
  parameter int CNT_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0]            in_ready,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [15:0]           out_data,
  input logic                  out_last,
  input logic                  cnt_clear,
  input logic [1:0][CNT_W-1:0] err_cnt,
  input logic [CNT_W-1:0]      both_bad_cnt,
  input logic [1:0]            link_ok,
  input logic                  sel_link
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R5

  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid); // R6

  AST_INPUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready == 2'b00); // R7

  AST_SEL_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> sel_link == (!link_ok[0] && link_ok[1])); // R3

  AST_BOTH_BAD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) && link_ok == 2'b00 && !$past(cnt_clear) |->
      both_bad_cnt == CNT_W'($past(both_bad_cnt) + 1'b1)); // R8

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> err_cnt == '0 && both_bad_cnt == '0); // R9
endmodule

bind crcsel_top crcsel_sva #(.CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
  .cnt_clear(cnt_clear), .err_cnt(err_cnt), .both_bad_cnt(both_bad_cnt),
  .link_ok(link_ok), .sel_link(sel_link)
);

// File: tb/crcsel_top_tb_top.sv
module crcsel_top_tb_top;
  localparam int DEPTH = 64;
  localparam int CNT_W = 16;

  typedef logic [15:0] wq_t [$];

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                  rst_n;
  logic [1:0]            in_ready;
  logic                  out_valid, out_ready, out_last, cnt_clear, sel_link;
  logic [15:0]           out_data;
  logic [1:0][CNT_W-1:0] err_cnt;
  logic [CNT_W-1:0]      both_bad_cnt;
  logic [1:0][15:0]      crc_even, crc_odd, crc_block;
  logic [1:0]            link_ok;

  logic        tv [2];
  logic [15:0] td [2];
  logic        tl [2];

  crcsel_top #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid({tv[1], tv[0]}), .in_ready(in_ready),
    .in_data({td[1], td[0]}), .in_last({tl[1], tl[0]}),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .cnt_clear(cnt_clear), .err_cnt(err_cnt),
    .both_bad_cnt(both_bad_cnt), .crc_even(crc_even), .crc_odd(crc_odd),
    .crc_block(crc_block), .link_ok(link_ok), .sel_link(sel_link)
  );

  int compared = 0, mismatched = 0;
  int m_err0 = 0, m_err1 = 0, m_bb = 0;
  int blocks_done = 0;
  bit bp_en = 0;
  bit sent [2];
  bit in_block = 0;
  logic [16:0] exp_q [$];

  task automatic chk(string req, string what, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_step(logic [15:0] c, logic [15:0] d);
    int x = c;
    for (int i = 0; i < 16; i++) begin
      int topbit = ((x >> 15) & 1) ^ ((d >> (15 - i)) & 1);
      x = (x << 1) & 16'hFFFF;
      if (topbit != 0) x = x ^ 16'h1021;
    end
    return x[15:0];
  endfunction

  // checksums over the first max(L-3,0) words: {even, odd, block}
  function automatic logic [47:0] ref_sums(wq_t q);
    logic [15:0] e = 16'hFFFF, o = 16'hFFFF, b = 16'hFFFF;
    int n = (q.size() >= 3) ? q.size() - 3 : 0;
    for (int i = 0; i < n; i++) begin
      if (i % 2 == 0) e = ref_step(e, q[i]);
      else            o = ref_step(o, q[i]);
      b = ref_step(b, q[i]);
    end
    return {e, o, b};
  endfunction

  function automatic wq_t build(int npay);
    wq_t q;
    logic [47:0] s;
    for (int i = 0; i < npay; i++) q.push_back(16'($urandom));
    q.push_back(16'h0); q.push_back(16'h0); q.push_back(16'h0);
    s = ref_sums(q);
    q[npay] = s[47:32]; q[npay+1] = s[31:16]; q[npay+2] = s[15:0];
    return q;
  endfunction

  function automatic wq_t flip(wq_t q, int idx);
    wq_t r = q;
    r[idx] = r[idx] ^ 16'h0100;
    return r;
  endfunction

  function automatic bit judged_ok(wq_t q);
    logic [47:0] s;
    int L = q.size();
    if (L < 4 || L > DEPTH) return 0;
    s = ref_sums(q);
    return (q[L-3] == s[47:32]) && (q[L-2] == s[31:16]) && (q[L-1] == s[15:0]);
  endfunction

  task automatic drive(int k, wq_t q, int gap);
    for (int i = 0; i < q.size(); i++) begin
      tv[k] = 1'b0;
      repeat ($urandom_range(0, gap)) @(negedge clk);
      tv[k] = 1'b1; td[k] = q[i]; tl[k] = (i == q.size() - 1);
      #1;
      while (!in_ready[k]) begin @(negedge clk); #1; end
      @(negedge clk);
    end
    tv[k] = 1'b0; tl[k] = 1'b0;
    sent[k] = 1'b1;
  endtask

  task automatic run_pair(wq_t a, wq_t b, int gap, int skew, string tag);
    bit ok0 = judged_ok(a), ok1 = judged_ok(b);
    bit s = !ok0 && ok1;
    wq_t ch = s ? b : a;
    int n = (ch.size() > DEPTH) ? DEPTH : ch.size();
    int target = blocks_done + 1;
    logic [47:0] sa = ref_sums(a), sb = ref_sums(b);
    for (int i = 0; i < n; i++) exp_q.push_back({(i == n - 1), ch[i]});
    m_err0 += !ok0; m_err1 += !ok1; m_bb += (!ok0 && !ok1);
    sent[0] = 0; sent[1] = 0;
    fork
      begin
        drive(0, a, gap);
        if (skew > 8) begin
          #1; chk("R7", {tag, " link0 ready after last"}, in_ready[0], 0);
        end
      end
      begin repeat (skew) @(negedge clk); drive(1, b, gap); end
    join
    wait (blocks_done == target);
    repeat (3) @(negedge clk);
    #2;
    chk("R3", {tag, " sel_link"}, sel_link, s);
    chk("R10", {tag, " link_ok"}, link_ok, {ok1, ok0});
    chk("R10", {tag, " crc even 0"}, crc_even[0], sa[47:32]);
    chk("R10", {tag, " crc odd 0"}, crc_odd[0], sa[31:16]);
    chk("R10", {tag, " crc block 1"}, crc_block[1], sb[15:0]);
    chk("R8", {tag, " err0"}, err_cnt[0], m_err0);
    chk("R8", {tag, " err1"}, err_cnt[1], m_err1);
    chk("R8", {tag, " both bad"}, both_bad_cnt, m_bb);
    chk("R6", {tag, " idle"}, out_valid, 0);
  endtask

  always @(negedge clk) out_ready <= bp_en ? ($urandom_range(0, 3) != 0) : 1'b1;

  // output monitor
  bit          hold_pend = 0;
  logic [16:0] hold_w, e;
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (hold_pend) begin
        chk("R5", "held word", {out_valid, out_last, out_data}, {1'b1, hold_w});
      end
      hold_pend = out_valid && !out_ready;
      hold_w = {out_last, out_data};
      if (out_valid && out_ready) begin
        if (!in_block) chk("R4", "both copies in before output", {sent[1], sent[0]}, 2'b11);
        in_block = 1;
        if (exp_q.size() == 0) begin
          chk("R4", "unexpected word", {out_last, out_data}, 17'h1ffff);
        end else begin
          e = exp_q.pop_front();
          chk("R4", "output word", {out_last, out_data}, e);
        end
        if (out_last) begin in_block = 0; blocks_done++; end
      end
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    wq_t g, h;
    rst_n = 0; cnt_clear = 0;
    tv[0] = 0; tv[1] = 0; tl[0] = 0; tl[1] = 0; td[0] = 0; td[1] = 0;
    repeat (4) @(negedge clk);
    #2;
    chk("R11", "reset out_valid", out_valid, 0);
    chk("R11", "reset in_ready", in_ready, 2'b11);
    chk("R11", "reset counters", {err_cnt, both_bad_cnt}, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);

    g = build(7);  run_pair(g, g, 0, 0, "R1 R2 both good");
    g = build(9);  run_pair(flip(g, 2), g, 1, 0, "R3 payload bad on 0");
    g = build(6);  run_pair(flip(g, 6), g, 0, 2, "R1 even trailer bad on 0");
    g = build(8);  run_pair(flip(g, 9), flip(g, 10), 0, 0, "R3 both bad odd/block");
    g = build(5);  run_pair(g, flip(g, 7), 1, 1, "R3 link1 bad");
    g = build(0);  h = build(2);
    run_pair(g, h, 0, 0, "R2 three-word block");
    g = build(1);  run_pair(g, g, 0, 0, "R2 minimum block");
    g = build(DEPTH - 3); run_pair(g, g, 0, 0, "R2 full depth");
    g = build(DEPTH);     run_pair(g, g, 0, 0, "R2 R4 oversize");
    g = build(20); run_pair(g, g, 0, 30, "R7 staggered");

    @(negedge clk); cnt_clear = 1; @(negedge clk); cnt_clear = 0;
    m_err0 = 0; m_err1 = 0; m_bb = 0;
    #2;
    chk("R9", "cleared counters", {err_cnt, both_bad_cnt}, 0);

    bp_en = 1;
    for (int it = 0; it < 25; it++) begin
      int md = $urandom_range(0, 3);
      int np = $urandom_range(1, 20);
      wq_t a, b;
      g = build(np);
      a = (md == 1 || md == 3) ? flip(g, $urandom_range(0, np + 2)) : g;
      b = (md == 2 || md == 3) ? flip(g, $urandom_range(0, np + 2)) : g;
      run_pair(a, b, 2, $urandom_range(0, 12), "R4 R5 random");
    end
    bp_en = 0;
    repeat (4) @(negedge clk);
    chk("R4", "leftover words", exp_q.size(), 0);
    finish_run();
  end
endmodule